// File: doc/BRIEF.md
# Wide-Word Burst Beat Serializer

This block sits on the controller side of a memory write path. It takes one 576-bit local write word, a 72-bit byte mask and a base column. It turns them into one burst of eight 72-bit memory beats. Beat k carries lane k of the word, which is bits 72k+71 down to 72k. It also carries that lane's nine write-enable bits and the column base+k. The beats go out in ascending lane order. One local transfer therefore becomes one eight-beat burst.

The block runs on a single clock. A beat-enable input decides in which cycles a beat may advance, which models the slower memory-beat rate without a clock-domain crossing. A load strobe captures the word while the block is idle. A busy output covers the whole burst. A load that arrives while busy is discarded and flagged in the same cycle.

Top module: `burst_beat_serializer`

## Requirements
- R1: After reset, busy, beat_valid, beat_last and load_drop are all 0.
- R2: A load seen while busy is 0 is accepted. Busy reads 1 from the next cycle onward, and exactly eight beats follow before busy returns to 0.
- R3: Beat k of a burst (k = 0 first, up to 7) carries wide_data[72k+71:72k] on beat_data.
- R4: Beat k carries the column {base_col[COL_W-1:3], k}. The three low bits of base_col are ignored, so the burst always covers one aligned block of 8 columns.
- R5: beat_wen[j] of beat k equals NOT wide_mask[9k+j]. It enables the write of byte j, which is beat_data[8j+7:8j]. A set mask bit keeps the old memory byte.
- R6: beat_last is 1 on the eighth beat of a burst and 0 on every other cycle.
- R7: While busy, a cycle with beat_en at 0 produces no beat (beat_valid 0), and the burst position and column are held.
- R8: A load while busy is 1 leaves the running burst unchanged, creates no beats, and drives load_drop to 1 in that same cycle.
- R9: In the cycle after the last beat, busy is 0 and a new load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_en | input | 1 | Allows one beat to advance in this cycle |
| load | input | 1 | Load strobe for a new local word |
| base_col | input | COL_W (10) | Base column; the low 3 bits are ignored |
| wide_data | input | 576 | Local write word, eight 72-bit lanes |
| wide_mask | input | 72 | Byte mask; 1 = do not write the byte |
| busy | output | 1 | A burst is in progress |
| load_drop | output | 1 | A load was discarded because busy was 1 |
| beat_valid | output | 1 | A beat is presented in this cycle |
| beat_last | output | 1 | The current beat is the eighth one |
| beat_col | output | COL_W (10) | Column of the current beat |
| beat_data | output | 72 | Data of the current beat |
| beat_wen | output | 9 | Per-byte write enables of the current beat |

## Verification
Two functions can fall in the same cycle: the final beat of a burst and a new load strobe. Since busy is still 1 in that cycle, the load must be dropped, and load_drop must rise while the eighth beat is still delivered intact. The bench provokes this by raising load on the exact cycle it observes beat_last. It then checks load_drop, checks that busy falls in the next cycle, and relies on the scoreboard to report any stray beat. It also applies the same kind of collision in the middle of a stalled burst, where beat_en is 0.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  localparam int unsigned BBS_LANES  = 8;
  localparam int unsigned BBS_LANE_W = 72;
  localparam int unsigned BBS_BYTE_W = 8;
  localparam int unsigned BBS_COL_W  = 10;

  function automatic int unsigned bbs_bytes_per_lane(input int unsigned lane_w,
                                                     input int unsigned byte_w);
    return lane_w / byte_w;
  endfunction
endpackage

// File: rtl/bbs_beat_ctrl.sv
module bbs_beat_ctrl #(
  parameter int unsigned LANES = 8,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             beat_en,
  output logic             accept,
  output logic             drop,
  output logic             step,
  output logic             last,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    accept = load & ~busy_q;
    drop   = load & busy_q;
    step   = busy_q & beat_en;
    last   = step & (idx_q == IDX_W'(LANES - 1));
    busy_d = busy_q;
    idx_d  = idx_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (step) begin
      idx_d = idx_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
endmodule

// File: rtl/bbs_hold_reg.sv
module bbs_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;

  always_comb q_d = en ? d : q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/bbs_lane_pick.sv
module bbs_lane_pick #(
  parameter int unsigned LANES = 8,
  parameter int unsigned W     = 72,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic [LANES*W-1:0] word,
  input  logic [IDX_W-1:0]   sel,
  output logic [W-1:0]       lane
);
  logic [W-1:0] lanes [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes[k] = word[k*W +: W];
  end

  assign lane = lanes[sel];
endmodule

// File: rtl/burst_beat_serializer.sv
module burst_beat_serializer
  import bbs_pkg::*;
#(
  parameter int unsigned LANES  = BBS_LANES,
  parameter int unsigned LANE_W = BBS_LANE_W,
  parameter int unsigned BYTE_W = BBS_BYTE_W,
  parameter int unsigned COL_W  = BBS_COL_W,
  localparam int unsigned IDX_W  = $clog2(LANES),
  localparam int unsigned NBYTES = bbs_bytes_per_lane(LANE_W, BYTE_W),
  localparam int unsigned WORD_W = LANES * LANE_W,
  localparam int unsigned MASK_W = LANES * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_en,
  input  logic              load,
  input  logic [COL_W-1:0]  base_col,
  input  logic [WORD_W-1:0] wide_data,
  input  logic [MASK_W-1:0] wide_mask,
  output logic              busy,
  output logic              load_drop,
  output logic              beat_valid,
  output logic              beat_last,
  output logic [COL_W-1:0]  beat_col,
  output logic [LANE_W-1:0] beat_data,
  output logic [NBYTES-1:0] beat_wen
);
  logic             accept, step;
  logic [IDX_W-1:0] idx;
  logic [WORD_W-1:0] data_q;
  logic [MASK_W-1:0] mask_q;
  logic [COL_W-IDX_W-1:0] blk_q;
  logic [NBYTES-1:0] mask_lane;

  bbs_beat_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .beat_en(beat_en),
    .accept(accept), .drop(load_drop), .step(step), .last(beat_last),
    .busy(busy), .idx(idx)
  );

  bbs_hold_reg #(.W(WORD_W)) u_data (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(wide_data), .q(data_q)
  );

  bbs_hold_reg #(.W(MASK_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(wide_mask), .q(mask_q)
  );

  bbs_hold_reg #(.W(COL_W-IDX_W)) u_base (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(base_col[COL_W-1:IDX_W]), .q(blk_q)
  );

  bbs_lane_pick #(.LANES(LANES), .W(LANE_W)) u_dpick (
    .word(data_q), .sel(idx), .lane(beat_data)
  );

  bbs_lane_pick #(.LANES(LANES), .W(NBYTES)) u_mpick (
    .word(mask_q), .sel(idx), .lane(mask_lane)
  );

  assign beat_valid = step;
  assign beat_col   = {blk_q, idx};
  assign beat_wen   = ~mask_lane;
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
  parameter int unsigned COL_W = 10,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             beat_en,
  input logic             busy,
  input logic             load_drop,
  input logic             beat_valid,
  input logic             beat_last,
  input logic [COL_W-1:0] beat_col
);
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load && !busy |=> busy); // R2
  AST_MID_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> busy); // R2
  AST_LAST_ON_TOP_COL: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_last == (beat_col[IDX_W-1:0] == {IDX_W{1'b1}}))); // R6
  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid); // R6
  AST_STALL_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_en |-> !beat_valid); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat_en |=> busy && $stable(beat_col)); // R7
  AST_DROP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_drop |-> busy && load); // R8
  AST_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !busy); // R9
endmodule

bind burst_beat_serializer bbs_checker #(.COL_W(COL_W), .IDX_W(IDX_W)) u_bbs_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .beat_en(beat_en), .busy(busy),
  .load_drop(load_drop), .beat_valid(beat_valid), .beat_last(beat_last),
  .beat_col(beat_col)
);

// File: tb/tb_burst_beat_serializer.sv
`timescale 1ns/1ps
module tb_burst_beat_serializer;
  localparam int COL_W = 10;
  localparam int LW = 72;
  localparam int NB = 9;

  typedef struct {
    logic [COL_W-1:0] col;
    logic [LW-1:0]    data;
    logic [NB-1:0]    wen;
    logic             last;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic beat_en = 1'b1;
  logic load = 1'b0;
  logic [COL_W-1:0] base_col = '0;
  logic [8*LW-1:0] wide_data = '0;
  logic [8*NB-1:0] wide_mask = '0;
  logic busy, load_drop, beat_valid, beat_last;
  logic [COL_W-1:0] beat_col;
  logic [LW-1:0] beat_data;
  logic [NB-1:0] beat_wen;

  int errors = 0;
  int checks = 0;
  bit stall_mode = 1'b0;
  int unsigned cyc = 0;
  beat_t expq[$];
  logic [LW-1:0] mem [1024];
  logic [LW-1:0] exp_mem [1024];

  always #4 clk = ~clk;

  burst_beat_serializer dut (
    .clk(clk), .rst_n(rst_n), .beat_en(beat_en), .load(load), .base_col(base_col),
    .wide_data(wide_data), .wide_mask(wide_mask), .busy(busy), .load_drop(load_drop),
    .beat_valid(beat_valid), .beat_last(beat_last), .beat_col(beat_col),
    .beat_data(beat_data), .beat_wen(beat_wen)
  );

  task automatic check(input bit ok, input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      beat_en = stall_mode ? ((cyc % 3) != 0) : 1'b1;
    end
  end

  // monitor: pops expected beats and models the memory
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy && !beat_en)
          check(beat_valid == 1'b0, "R7 stall beat_valid", LW'(beat_valid), '0);
        if (beat_valid) begin
          if (expq.size() == 0) begin
            check(1'b0, "R2/R8 unexpected beat", LW'(beat_col), '0);
          end else begin
            beat_t e;
            e = expq.pop_front();
            check(beat_col == e.col, "R4 column", LW'(beat_col), LW'(e.col));
            check(beat_data == e.data, "R3 lane data", beat_data, e.data);
            check(beat_wen == e.wen, "R5 write enables", LW'(beat_wen), LW'(e.wen));
            check(beat_last == e.last, "R6 last marker", LW'(beat_last), LW'(e.last));
          end
          for (int j = 0; j < NB; j++)
            if (beat_wen[j]) mem[beat_col][8*j +: 8] = beat_data[8*j +: 8];
        end else begin
          check(beat_last == 1'b0, "R6 last without beat", LW'(beat_last), '0);
        end
      end
    end
  end

  function automatic logic [8*LW-1:0] make_word(input logic [31:0] seed);
    logic [8*LW-1:0] w;
    for (int k = 0; k < 8; k++)
      w[k*LW +: LW] = {8'(k), seed + 32'(k), seed ^ {4{8'(k * 17)}}};
    return w;
  endfunction

  task automatic send(input logic [COL_W-1:0] b, input logic [8*LW-1:0] d,
                      input logic [8*NB-1:0] m);
    @(negedge clk);
    while (busy) @(negedge clk);
    base_col = b; wide_data = d; wide_mask = m; load = 1'b1;
    for (int k = 0; k < 8; k++) begin
      beat_t e;
      e.col  = {b[COL_W-1:3], 3'(k)};
      e.data = d[k*LW +: LW];
      e.wen  = ~m[k*NB +: NB];
      e.last = (k == 7);
      expq.push_back(e);
      for (int j = 0; j < NB; j++)
        if (!m[k*NB + j]) exp_mem[e.col][8*j +: 8] = e.data[8*j +: 8];
    end
    @(posedge clk);
    #1 load = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after load", LW'(busy), 1);
  endtask

  task automatic intrude(input bool_at_last);
    @(negedge clk);
    if (bool_at_last) while (!beat_last) @(negedge clk);
    else while (!busy || beat_last) @(negedge clk);
    base_col = 10'h155; wide_data = make_word(32'hDEAD_0000); wide_mask = '0;
    load = 1'b1;
    #1;
    check(load_drop == 1'b1, "R8 load_drop on busy load", LW'(load_drop), 1);
    @(posedge clk);
    #1 load = 1'b0;
    if (bool_at_last) begin
      @(negedge clk);
      check(busy == 1'b0, "R9 busy low after last beat", LW'(busy), 0);
    end
  endtask

  initial begin
    for (int c = 0; c < 1024; c++) begin
      mem[c] = {8'hEE, 32'(c), 32'hC0DE_0000 + 32'(c)};
      exp_mem[c] = mem[c];
    end
    #20;
    check(busy == 1'b0 && beat_valid == 1'b0 && beat_last == 1'b0 && load_drop == 1'b0,
          "R1 reset outputs", LW'({busy, beat_valid, beat_last, load_drop}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    send(10'h000, make_word(32'h1111_0000), '0);
    send(10'h0A5, make_word(32'h2222_0000), {18{4'hF}});
    send(10'h3F8, make_word(32'h3333_0000), 72'h5A_0F0F_F0F0_1234_8001);
    intrude(1'b1);
    // R9: accept right after the freed cycle
    send(10'h040, make_word(32'h4444_0000), 72'h00_0000_0000_0000_01FF);
    stall_mode = 1'b1;
    send(10'h108, make_word(32'h5555_0000), 72'hFF_8000_0000_0000_0000);
    intrude(1'b0);
    intrude(1'b1);
    send(10'h20F, make_word(32'h6666_0000), 72'h12_3456_789A_BCDE_F012);
    stall_mode = 1'b0;
    send(10'h000, make_word(32'h7777_0000), 72'h01_0000_0000_0000_0000);

    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R2 eight beats per burst", LW'(expq.size()), 0);
    for (int c = 0; c < 1024; c++)
      if (mem[c] != exp_mem[c]) check(1'b0, "R5 memory contents", mem[c], exp_mem[c]);
    check(1'b1, "R5 memory scan", '0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule